// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a watchdog peripheral that measures time by comparing a free-running system count against a stored deadline. It does not count down. Software programs a timeout offset and sets the enable bit. From then on the block holds a deadline equal to the count at that moment plus the offset.

If software lets the deadline pass without a restart, the block raises a warning level. It also moves the deadline one more offset ahead. If that second deadline passes too, a final level rises. The final level is meant to drive a reset or a high-priority interrupt. A full escalation with no restart therefore takes twice the offset.

Registers sit in two 4 KiB frames on a simple 32-bit read/write bus. A control frame holds enable, status, offset, deadline and an identification word. A separate restart frame holds the restart register and its own identification word. Address bit 12 chooses the frame.

Top module: `wdt_twostage`

## Requirements
- R1: After reset the enable bit, both stage flags, the offset and the deadline are zero, `wdog_warn` and `wdog_final` are low, and `rsp_rdata` is zero.
- R2: `req_addr[12]` = 0 selects the control frame. At offset 0x000 of that frame sits the control word: bit 0 is enable, bit 1 is the first-stage flag, bit 2 is the second-stage flag, and all other bits read zero. Offset 0x008 holds the offset, 0x010 the deadline bits 31:0, and 0x014 the deadline bits 63:32, with bits above CNT_W reading zero. Offset 0xFCC returns CTRL_ID. Address bits 1:0 are ignored.
- R3: A read request is answered on `rsp_rdata` after the next rising clock edge, with the register value from before that edge. `rsp_rdata` holds until the next read. Reads of unmapped offsets return zero. In the restart frame (`req_addr[12]` = 1), offset 0x000 reads zero and 0xFCC returns RFSH_ID.
- R4: A write of any value to restart-frame offset 0x000 loads the deadline with count + offset and clears both stage flags.
- R5: A control write with bit 0 = 1 while disabled sets enable, loads the deadline with count + offset and clears both flags. The same write while already enabled changes nothing.
- R6: A control write with bit 0 = 0 clears enable and both flags. While disabled no timeout occurs, whatever the count.
- R7: A write to offset 0x008 stores `req_wdata[OFS_W-1:0]` (upper bits dropped). It also acts as a restart using the new offset.
- R8: When enabled, with the first-stage flag clear and count >= deadline, the first-stage flag sets and the deadline reloads to count + offset.
- R9: When enabled, with the first-stage flag set and count >= deadline, the second-stage flag sets. Both flags then hold until a restart or a disable. With a count that advances by one per cycle, escalation takes 2×offset cycles after the restart (2 cycles for offset 0).
- R10: `wdog_warn` equals the first-stage flag and `wdog_final` equals the second-stage flag, as levels.
- R11: Writes to either ID word and to unmapped offsets change no state.
- R12: A restart in the same cycle as a reached deadline wins: no stage flag sets that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_count | input | CNT_W | Free-running system count |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address; bit 12 selects the frame |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| wdog_warn | output | 1 | First-stage timeout level |
| wdog_final | output | 1 | Second-stage timeout level |

## Verification
The bench builds the block with CNT_W = 40 and OFS_W = 6. The narrow offset lets it sweep every offset value from 0 to 63 through a full two-stage escalation and measure both delays in cycles. Each sweep starts the count just below a 32-bit boundary, so the deadline carries into the upper deadline word. Wide write data exposes the truncation of the offset field. A cycle model built from the requirements predicts every output level and read value.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

  localparam int unsigned FRAME_BYTES = 4096;
  localparam int unsigned FRAME_AW    = $clog2(FRAME_BYTES);
  localparam int unsigned BUS_AW      = FRAME_AW + 1;
  localparam int unsigned BUS_DW      = 32;
  localparam int unsigned CMP_VIEW_W  = 2 * BUS_DW;

  localparam logic [FRAME_AW-1:0] OFF_CTRL   = 12'h000;
  localparam logic [FRAME_AW-1:0] OFF_OFS    = 12'h008;
  localparam logic [FRAME_AW-1:0] OFF_CMP_LO = 12'h010;
  localparam logic [FRAME_AW-1:0] OFF_CMP_HI = 12'h014;
  localparam logic [FRAME_AW-1:0] OFF_IDENT  = 12'hFCC;
  localparam logic [FRAME_AW-1:0] OFF_KICK   = 12'h000;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_WS0_BIT = 1;
  localparam int unsigned CTRL_WS1_BIT = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_OFS,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_CID,
    SEL_KICK,
    SEL_RID
  } reg_sel_e;

  typedef struct packed {
    logic ctrl;
    logic ofs;
    logic kick;
  } wr_strobe_t;

  function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] addr);
    logic [FRAME_AW-1:0] word;
    reg_sel_e sel;
    word = {addr[FRAME_AW-1:2], 2'b00};
    sel  = SEL_NONE;
    if (addr[BUS_AW-1]) begin
      case (word)
        OFF_KICK:  sel = SEL_KICK;
        OFF_IDENT: sel = SEL_RID;
        default:   sel = SEL_NONE;
      endcase
    end else begin
      case (word)
        OFF_CTRL:   sel = SEL_CTRL;
        OFF_OFS:    sel = SEL_OFS;
        OFF_CMP_LO: sel = SEL_CMP_LO;
        OFF_CMP_HI: sel = SEL_CMP_HI;
        OFF_IDENT:  sel = SEL_CID;
        default:    sel = SEL_NONE;
      endcase
    end
    return sel;
  endfunction

endpackage

// File: rtl/wdt_rst_sync.sv
`timescale 1ns/1ps
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/wdt_regif.sv
`timescale 1ns/1ps
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned OFS_W   = 32,
  parameter logic [31:0] CTRL_ID = 32'h0000_0000,
  parameter logic [31:0] RFSH_ID = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BUS_AW-1:0] req_addr,
  input  logic [BUS_DW-1:0] req_wdata,
  output logic [BUS_DW-1:0] rsp_rdata,
  output wr_strobe_t        wr_stb,
  output logic              wr_en_val,
  output logic [OFS_W-1:0]  wr_ofs_val,
  input  logic              st_en,
  input  logic              st_ws0,
  input  logic              st_ws1,
  input  logic [OFS_W-1:0]  st_ofs,
  input  logic [CNT_W-1:0]  st_cmp
);

  reg_sel_e                sel;
  logic                    do_wr;
  logic                    do_rd;
  logic [CMP_VIEW_W-1:0]   cmp_view;
  logic [BUS_DW-1:0]       rd_val;
  logic [BUS_DW-1:0]       rdata_q;

  assign sel        = decode_addr(req_addr);
  assign do_wr      = req_valid && req_write;
  assign do_rd      = req_valid && !req_write;
  assign cmp_view   = CMP_VIEW_W'(st_cmp);
  assign wr_en_val  = req_wdata[CTRL_EN_BIT];
  assign wr_ofs_val = req_wdata[OFS_W-1:0];

  // write strobes: one register at most per cycle
  always_comb begin
    wr_stb = '0;
    if (do_wr) begin
      case (sel)
        SEL_CTRL: wr_stb.ctrl = 1'b1;
        SEL_OFS:  wr_stb.ofs  = 1'b1;
        SEL_KICK: wr_stb.kick = 1'b1;
        default:  wr_stb      = '0;
      endcase
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_CTRL: begin
        rd_val[CTRL_EN_BIT]  = st_en;
        rd_val[CTRL_WS0_BIT] = st_ws0;
        rd_val[CTRL_WS1_BIT] = st_ws1;
      end
      SEL_OFS:    rd_val = BUS_DW'(st_ofs);
      SEL_CMP_LO: rd_val = cmp_view[BUS_DW-1:0];
      SEL_CMP_HI: rd_val = cmp_view[CMP_VIEW_W-1:BUS_DW];
      SEL_CID:    rd_val = CTRL_ID;
      SEL_RID:    rd_val = RFSH_ID;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (do_rd) begin
      rdata_q <= rd_val;
    end
  end

  assign rsp_rdata = rdata_q;

  a_r11_single_strobe : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  a_r3_rdata_holds : assert property (@(posedge clk) disable iff (!rst_n)
    !do_rd |=> $stable(rsp_rdata));

endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned OFS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  wr_strobe_t       wr_stb,
  input  logic             wr_en_val,
  input  logic [OFS_W-1:0] wr_ofs_val,
  output logic             en,
  output logic             ws0,
  output logic             ws1,
  output logic [OFS_W-1:0] ofs,
  output logic [CNT_W-1:0] cmp
);

  logic             en_q,  en_d;
  logic             ws0_q, ws0_d;
  logic             ws1_q, ws1_d;
  logic [OFS_W-1:0] ofs_q;
  logic [CNT_W-1:0] cmp_q;
  logic [OFS_W-1:0] ofs_eff;
  logic [CNT_W-1:0] reload;
  logic             enable_rise;
  logic             disable_req;
  logic             restart;
  logic             reached;
  logic             cmp_ld;
  logic             ofs_ld;

  assign ofs_ld      = wr_stb.ofs;
  assign ofs_eff     = ofs_ld ? wr_ofs_val : ofs_q;
  assign reload      = count + CNT_W'(ofs_eff);
  assign enable_rise = wr_stb.ctrl && wr_en_val && !en_q;
  assign disable_req = wr_stb.ctrl && !wr_en_val;
  assign restart     = wr_stb.kick || wr_stb.ofs || enable_rise;
  assign reached     = en_q && (count >= cmp_q);

  // next state: disable, then restart, then timeout
  always_comb begin
    en_d   = en_q;
    ws0_d  = ws0_q;
    ws1_d  = ws1_q;
    cmp_ld = 1'b0;
    if (disable_req) begin
      en_d  = 1'b0;
      ws0_d = 1'b0;
      ws1_d = 1'b0;
    end else if (restart) begin
      if (enable_rise) begin
        en_d = 1'b1;
      end
      ws0_d  = 1'b0;
      ws1_d  = 1'b0;
      cmp_ld = 1'b1;
    end else if (reached) begin
      if (!ws0_q) begin
        ws0_d  = 1'b1;
        cmp_ld = 1'b1;
      end else begin
        ws1_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ws0_q <= 1'b0;
      ws1_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      ws0_q <= ws0_d;
      ws1_q <= ws1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (ofs_ld) begin
      ofs_q <= wr_ofs_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_ld) begin
      cmp_q <= reload;
    end
  end

  assign en  = en_q;
  assign ws0 = ws0_q;
  assign ws1 = ws1_q;
  assign ofs = ofs_q;
  assign cmp = cmp_q;

  a_r9_second_implies_first : assert property (@(posedge clk) disable iff (!rst_n)
    ws1_q |-> ws0_q);

  a_r6_disabled_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!ws0_q && !ws1_q));

  a_r4_kick_restarts : assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb.kick |=> (!ws0_q && !ws1_q &&
                     cmp_q == CNT_W'($past(count) + CNT_W'($past(ofs_q)))));

  a_r8_first_stage_reload : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws0_q) |-> (cmp_q == CNT_W'($past(count) + CNT_W'($past(ofs_q)))));

  a_r9_second_after_first : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws1_q) |-> $past(ws0_q));

  a_r12_restart_wins : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb.kick && en_q && count >= cmp_q) |=> !ws0_q);

endmodule

// File: rtl/wdt_twostage.sv
`timescale 1ns/1ps
module wdt_twostage
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned OFS_W   = 32,
  parameter logic [31:0] CTRL_ID = 32'h5D07_0101,
  parameter logic [31:0] RFSH_ID = 32'h5D07_0102
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BUS_AW-1:0] req_addr,
  input  logic [BUS_DW-1:0] req_wdata,
  output logic [BUS_DW-1:0] rsp_rdata,
  output logic              wdog_warn,
  output logic              wdog_final
);

  logic             rst_n;
  wr_strobe_t       wr_stb;
  logic             wr_en_val;
  logic [OFS_W-1:0] wr_ofs_val;
  logic             st_en;
  logic             st_ws0;
  logic             st_ws1;
  logic [OFS_W-1:0] st_ofs;
  logic [CNT_W-1:0] st_cmp;

  wdt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  wdt_regif #(
    .CNT_W   (CNT_W),
    .OFS_W   (OFS_W),
    .CTRL_ID (CTRL_ID),
    .RFSH_ID (RFSH_ID)
  ) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_rdata  (rsp_rdata),
    .wr_stb     (wr_stb),
    .wr_en_val  (wr_en_val),
    .wr_ofs_val (wr_ofs_val),
    .st_en      (st_en),
    .st_ws0     (st_ws0),
    .st_ws1     (st_ws1),
    .st_ofs     (st_ofs),
    .st_cmp     (st_cmp)
  );

  wdt_core #(
    .CNT_W (CNT_W),
    .OFS_W (OFS_W)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (sys_count),
    .wr_stb     (wr_stb),
    .wr_en_val  (wr_en_val),
    .wr_ofs_val (wr_ofs_val),
    .en         (st_en),
    .ws0        (st_ws0),
    .ws1        (st_ws1),
    .ofs        (st_ofs),
    .cmp        (st_cmp)
  );

  assign wdog_warn  = st_ws0;
  assign wdog_final = st_ws1;

  a_r10_levels_follow : assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_final |-> wdog_warn));

endmodule

// File: tb/wdt_twostage_tb_top.sv
`timescale 1ns/1ps
module wdt_twostage_tb_top;

  localparam int unsigned CW = 40;
  localparam int unsigned OW = 6;
  localparam logic [31:0] CID = 32'h0A1B_2C3D;
  localparam logic [31:0] RID = 32'h0A1B_2C3E;

  localparam logic [12:0] A_CTRL = 13'h0000;
  localparam logic [12:0] A_OFS  = 13'h0008;
  localparam logic [12:0] A_LO   = 13'h0010;
  localparam logic [12:0] A_HI   = 13'h0014;
  localparam logic [12:0] A_CID  = 13'h0FCC;
  localparam logic [12:0] A_KICK = 13'h1000;
  localparam logic [12:0] A_RID  = 13'h1FCC;

  logic          clk;
  logic          arst_n;
  logic [CW-1:0] cnt;
  logic          req_valid;
  logic          req_write;
  logic [12:0]   req_addr;
  logic [31:0]   req_wdata;
  logic [31:0]   rsp_rdata;
  logic          warn;
  logic          fin;

  int n_vec;
  int n_bad;

  logic          m_en;
  logic          m_ws0;
  logic          m_ws1;
  logic [OW-1:0] m_ofs;
  logic [CW-1:0] m_cmp;
  logic [CW-1:0] now;

  wdt_twostage #(
    .CNT_W   (CW),
    .OFS_W   (OW),
    .CTRL_ID (CID),
    .RFSH_ID (RID)
  ) dut_i (
    .clk        (clk),
    .arst_n     (arst_n),
    .sys_count  (cnt),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_rdata  (rsp_rdata),
    .wdog_warn  (warn),
    .wdog_final (fin)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [12:0] a);
    logic [11:0] o;
    o = {a[11:2], 2'b00};
    if (a[12]) return (o == 12'hFCC) ? RID : 32'd0;
    case (o)
      12'h000: return {29'd0, m_ws1, m_ws0, m_en};
      12'h008: return 32'(m_ofs);
      12'h010: return m_cmp[31:0];
      12'h014: return 32'(m_cmp[CW-1:32]);
      12'hFCC: return CID;
      default: return 32'd0;
    endcase
  endfunction

  // one bus cycle at count "now"; model from the requirements, then compare
  task automatic cyc(input logic v, input logic w, input logic [12:0] a,
                     input logic [31:0] d, input string tag);
    logic [31:0] er;
    logic        rd;
    logic [11:0] o;
    logic        is_ctrl, is_ofs, is_kick, dis, enr;
    @(negedge clk);
    req_valid = v;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    cnt       = now;
    rd = v && !w;
    er = m_read(a);
    o  = {a[11:2], 2'b00};
    is_ctrl = v && w && !a[12] && (o == 12'h000);
    is_ofs  = v && w && !a[12] && (o == 12'h008);
    is_kick = v && w &&  a[12] && (o == 12'h000);
    dis = is_ctrl && !d[0];
    enr = is_ctrl && d[0] && !m_en;
    if (is_ofs) m_ofs = d[OW-1:0];
    if (dis) begin
      m_en = 0; m_ws0 = 0; m_ws1 = 0;
    end else if (enr || is_ofs || is_kick) begin
      if (enr) m_en = 1;
      m_ws0 = 0; m_ws1 = 0;
      m_cmp = now + CW'(m_ofs);
    end else if (m_en && now >= m_cmp) begin
      if (!m_ws0) begin
        m_ws0 = 1;
        m_cmp = now + CW'(m_ofs);
      end else begin
        m_ws1 = 1;
      end
    end
    @(posedge clk);
    #1;
    check({tag, " R10 warn"}, 64'(warn), 64'(m_ws0));
    check({tag, " R10 final"}, 64'(fin), 64'(m_ws1));
    if (rd) check({tag, " rdata"}, 64'(rsp_rdata), 64'(er));
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, tag);
  endtask

  task automatic rd(input logic [12:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'd0, tag);
  endtask

  task automatic idle(input string tag);
    now = now + 1;
    cyc(1'b0, 1'b0, 13'd0, 32'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int wk, fk, step;
    logic [31:0] keep_lo, keep_ofs, keep_ctrl;
    n_vec = 0; n_bad = 0;
    m_en = 0; m_ws0 = 0; m_ws1 = 0; m_ofs = '0; m_cmp = '0; now = '0;
    arst_n = 1'b0; cnt = '0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 warn", 64'(warn), 64'd0);
    check("R1 final", 64'(fin), 64'd0);
    check("R1 rdata", 64'(rsp_rdata), 64'd0);
    rd(A_CTRL, "R1"); rd(A_OFS, "R1"); rd(A_LO, "R1"); rd(A_HI, "R1");
    rd(A_CID, "R2"); check("R2 ctrl id", 64'(rsp_rdata), 64'(CID));
    rd(A_RID, "R3"); check("R3 restart id", 64'(rsp_rdata), 64'(RID));

    // exhaustive offset sweep across a 32-bit carry
    for (int o = 0; o < 64; o++) begin
      now = 40'h0F_FFFF_FFC0 + CW'(o);
      wr(A_CTRL, 32'd0, "R6");
      wr(A_OFS, 32'hFFFF_FFC0 | 32'(o), "R7");
      rd(A_OFS, "R7");
      check("R7 truncated offset", 64'(rsp_rdata), 64'(o));
      wr(A_CTRL, 32'd1, "R5");
      step = (o == 0) ? 1 : o;
      wk = 0; fk = 0;
      for (int k = 1; k <= 2 * step + 2; k++) begin
        idle("R9");
        if (warn && wk == 0) wk = k;
        if (fin && fk == 0) fk = k;
      end
      check("R8 first-stage delay", 64'(wk), 64'(step));
      check("R9 escalation delay", 64'(fk), 64'(2 * step));
      rd(A_LO, "R2"); rd(A_HI, "R2"); rd(A_CTRL, "R2");
      check("R2 ctrl all set", 64'(rsp_rdata), 64'h7);
    end

    // disable clears and stays quiet
    wr(A_CTRL, 32'd0, "R6");
    check("R6 warn cleared", 64'(warn), 64'd0);
    now = now + 1000;
    for (int k = 0; k < 20; k++) idle("R6");
    check("R6 still quiet", 64'({warn, fin}), 64'd0);

    // restart in the first stage postpones the warning
    wr(A_OFS, 32'd10, "R7");
    wr(A_CTRL, 32'd1, "R5");
    for (int k = 0; k < 6; k++) idle("R4");
    wr(A_KICK, 32'hDEAD_BEEF, "R4");
    for (int k = 0; k < 9; k++) idle("R4");
    check("R4 no early warn", 64'(warn), 64'd0);
    idle("R4");
    check("R4 warn at new deadline", 64'(warn), 64'd1);
    idle("R10");
    check("R10 warn level holds", 64'(warn), 64'd1);
    wr(A_KICK, 32'd0, "R4");
    check("R4 kick clears warn", 64'(warn), 64'd0);

    // enable while enabled does not reload
    rd(A_LO, "R5"); keep_lo = rsp_rdata;
    idle("R5"); idle("R5");
    wr(A_CTRL, 32'd1, "R5");
    rd(A_LO, "R5");
    check("R5 no reload when enabled", 64'(rsp_rdata), 64'(keep_lo));

    // ignored writes
    rd(A_OFS, "R11"); keep_ofs = rsp_rdata;
    rd(A_CTRL, "R11"); keep_ctrl = rsp_rdata;
    wr(A_CID, 32'hFFFF_FFFF, "R11");
    wr(A_RID, 32'hFFFF_FFFF, "R11");
    wr(13'h0004, 32'hFFFF_FFFF, "R11");
    wr(13'h1008, 32'hFFFF_FFFF, "R11");
    wr(13'h0018, 32'hFFFF_FFFF, "R11");
    rd(A_OFS, "R11"); check("R11 offset kept", 64'(rsp_rdata), 64'(keep_ofs));
    rd(A_LO, "R11");  check("R11 deadline kept", 64'(rsp_rdata), 64'(keep_lo));
    rd(A_CTRL, "R11"); check("R11 ctrl kept", 64'(rsp_rdata), 64'(keep_ctrl));

    // unmapped reads, hold, ignored low address bits
    rd(13'h0004, "R3"); check("R3 unmapped zero", 64'(rsp_rdata), 64'd0);
    rd(A_KICK, "R3");   check("R3 restart reg reads zero", 64'(rsp_rdata), 64'd0);
    rd(13'h1FF0, "R3"); check("R3 unmapped restart frame", 64'(rsp_rdata), 64'd0);
    rd(A_CID, "R3");
    idle("R3"); idle("R3");
    check("R3 rdata holds", 64'(rsp_rdata), 64'(CID));
    rd(13'h000B, "R2"); check("R2 low bits ignored", 64'(rsp_rdata), 64'(keep_ofs));

    // restart and reached deadline in one cycle
    wr(A_OFS, 32'd4, "R12");
    for (int k = 0; k < 3; k++) idle("R12");
    now = now + 1;
    wr(A_KICK, 32'd1, "R12");
    check("R12 restart wins", 64'(warn), 64'd0);
    for (int k = 0; k < 4; k++) idle("R12");
    check("R12 warn after new deadline", 64'(warn), 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule